// File: doc/BRIEF.md
# Power-Down Mode Transition Controller

This block follows the operating mode of a small microcontroller core. It knows seven modes: two full-rate active modes (high-speed and medium-speed), a subclock-driven active mode (subactive), and four low-power modes (sleep, subsleep, standby and watch). When the core executes its sleep instruction it raises a one-cycle strobe. The block then chooses the next mode from five control bits held elsewhere in the chip: a direct-transfer enable, a software-standby bit, a medium-speed select, a low-speed select and a timer-mode bit. A wake event brings the block back from any low-power mode.

With direct transfer enabled, the sleep instruction changes clock speed without passing through a low-power mode. It switches among high-speed, medium-speed and subactive only when the control bits form one of a fixed set of combinations. Any combination that matches no rule leaves the mode unchanged.

The mode is shown on a one-hot output and on a 2-bit clock-select code for the clock generator. Both come from the same mode register and change on the same clock edge. Register access, oscillator settling and interrupt arbitration are handled outside the block.

Top module: `pdm_mode_ctrl`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises, the mode is high-speed active. That is mode_oh = 7'b0000001 and clk_sel = 2'b00.
- R2: With dxfer_en=0, a sleep_req in high-speed or medium-speed active goes to sleep if sw_stby=0. It goes to standby if sw_stby=1 and tmr_sel=0, and to watch if sw_stby=1 and tmr_sel=1.
- R3: With dxfer_en=0, a sleep_req in subactive goes to subsleep if sw_stby=0 and to watch if sw_stby=1 and tmr_sel=1. It keeps subactive if sw_stby=1 and tmr_sel=0.
- R4: With dxfer_en=1, a sleep_req in high-speed active goes to medium-speed active when sw_stby=0, med_sel=1 and low_sel=0. It goes to subactive when sw_stby=1, tmr_sel=1 and low_sel=1.
- R5: With dxfer_en=1, a sleep_req in medium-speed active goes to high-speed active when sw_stby=0, med_sel=0 and low_sel=0. It goes to subactive when sw_stby=1, tmr_sel=1 and low_sel=1.
- R6: With dxfer_en=1, a sleep_req in subactive needs sw_stby=1, tmr_sel=1 and low_sel=0. It then goes to high-speed active if med_sel=0, or to medium-speed active if med_sel=1.
- R7: With dxfer_en=1, a sleep_req whose control bits match none of the rules in R4 to R6 leaves the mode unchanged.
- R8: A wake_evt in sleep or standby returns to medium-speed active if med_sel=1, otherwise to high-speed active.
- R9: A wake_evt in watch returns to subactive if low_sel=1. If low_sel=0 it returns to the active mode chosen by med_sel as in R8.
- R10: A wake_evt in subsleep returns to subactive.
- R11: A sleep_req in a low-power mode is ignored. A wake_evt in high-speed, medium-speed or subactive is ignored. With neither event the mode holds.
- R12: clk_sel is 2'b00 in high-speed active and in sleep, 2'b01 in medium-speed active, 2'b10 in subactive and subsleep, and 2'b11 in standby and watch.
- R13: mode_oh has exactly one bit set. The bits are: [0] high-speed, [1] medium-speed, [2] subactive, [3] sleep, [4] subsleep, [5] standby, [6] watch. The output changes on the clock edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | One-cycle strobe for an executed sleep instruction |
| wake_evt | input | 1 | Wake event that clears low-power modes |
| dxfer_en | input | 1 | Direct-transfer enable |
| sw_stby | input | 1 | Software standby bit |
| med_sel | input | 1 | Medium-speed select |
| low_sel | input | 1 | Low-speed (subclock) select |
| tmr_sel | input | 1 | Timer-mode bit |
| mode_oh | output | 7 | One-hot current mode (bit order in R13) |
| clk_sel | output | 2 | Clock-select code (encoding in R12) |

## Verification
The bench builds the block with its package defaults: seven modes and a 2-bit clock-select code. These are the only values the transition rules define, so all mode pairs and all 32 control-bit combinations can be reached. Directed steps first walk through each direct-transfer rule and the stay-put cases of R3 and R7. A seeded random run then mixes sleep and wake events with random control bits, so that every low-power mode is entered and left many times with both med_sel and low_sel settings.

// File: rtl/pdm_pkg.sv
// Package pdm_pkg: shared mode encoding, control-bit bundle and clock-select codes
// for the power-down mode controller. Assumes exactly seven operating modes.
package pdm_pkg;

    localparam int NUM_MODES = 7;
    localparam int MODE_W    = $clog2(NUM_MODES);
    localparam int CSEL_W    = 2;

    localparam logic [CSEL_W-1:0] CSEL_FULL = 2'b00;
    localparam logic [CSEL_W-1:0] CSEL_MED  = 2'b01;
    localparam logic [CSEL_W-1:0] CSEL_SUB  = 2'b10;
    localparam logic [CSEL_W-1:0] CSEL_STOP = 2'b11;

    typedef enum logic [MODE_W-1:0] {
        M_HS    = 3'd0,
        M_MS    = 3'd1,
        M_SUB   = 3'd2,
        M_SLP   = 3'd3,
        M_SSLP  = 3'd4,
        M_STBY  = 3'd5,
        M_WATCH = 3'd6
    } mode_e;

    typedef struct packed {
        logic dxfer;
        logic sstby;
        logic msel;
        logic lsel;
        logic tmode;
    } ctl_t;

endpackage

// File: rtl/pdm_next_decode.sv
// Module pdm_next_decode: combinational next-mode selection.
// Assumes sleep and wake are already qualified single-cycle events. In active
// modes only the sleep event counts, and in low-power modes only the wake event.
// Any combination the rules leave open returns the current mode.
module pdm_next_decode
    import pdm_pkg::*;
(
    input  mode_e cur_mode,
    input  logic  sleep_ev,
    input  logic  wake_ev,
    input  ctl_t  ctl,
    output mode_e nxt_mode
);

    mode_e resume_act;

    // Active mode chosen on wake from a full-clock low-power mode
    always_comb resume_act = ctl.msel ? M_MS : M_HS;

    // Transition table
    always_comb begin
        nxt_mode = cur_mode;
        unique case (cur_mode)
            M_HS, M_MS: begin
                if (sleep_ev) begin
                    if (!ctl.dxfer) begin
                        if (!ctl.sstby)      nxt_mode = M_SLP;
                        else if (!ctl.tmode) nxt_mode = M_STBY;
                        else                 nxt_mode = M_WATCH;
                    end else if (ctl.sstby && ctl.tmode && ctl.lsel) begin
                        nxt_mode = M_SUB;
                    end else if (!ctl.sstby && !ctl.lsel) begin
                        if (cur_mode == M_HS && ctl.msel)       nxt_mode = M_MS;
                        else if (cur_mode == M_MS && !ctl.msel) nxt_mode = M_HS;
                    end
                end
            end
            M_SUB: begin
                if (sleep_ev) begin
                    if (!ctl.dxfer) begin
                        if (!ctl.sstby)     nxt_mode = M_SSLP;
                        else if (ctl.tmode) nxt_mode = M_WATCH;
                    end else if (ctl.sstby && ctl.tmode && !ctl.lsel) begin
                        nxt_mode = resume_act;
                    end
                end
            end
            M_SLP, M_STBY: if (wake_ev) nxt_mode = resume_act;
            M_WATCH:       if (wake_ev) nxt_mode = ctl.lsel ? M_SUB : resume_act;
            M_SSLP:        if (wake_ev) nxt_mode = M_SUB;
            default:       nxt_mode = M_HS;
        endcase
    end

endmodule

// File: rtl/pdm_mode_reg.sv
// Module pdm_mode_reg: holds the current mode. Synchronous active-low reset
// to high-speed active. Loads the decoder result on every clock edge.
module pdm_mode_reg
    import pdm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e nxt_mode,
    output mode_e cur_mode
);

    // Mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) cur_mode <= M_HS;
        else        cur_mode <= nxt_mode;
    end

endmodule

// File: rtl/pdm_out_encode.sv
// Module pdm_out_encode: turns the registered mode into a one-hot vector and a
// clock-select code. Pure decode of a register, so both outputs change together.
module pdm_out_encode
    import pdm_pkg::*;
(
    input  mode_e               cur_mode,
    output logic [NUM_MODES-1:0] mode_oh,
    output logic [CSEL_W-1:0]    clk_sel
);

    // One decoder bit per mode
    for (genvar i = 0; i < NUM_MODES; i++) begin : g_oh
        assign mode_oh[i] = (cur_mode == mode_e'(MODE_W'(i)));
    end

    // Clock source requested from the clock generator
    always_comb begin
        unique case (cur_mode)
            M_HS, M_SLP:     clk_sel = CSEL_FULL;
            M_MS:            clk_sel = CSEL_MED;
            M_SUB, M_SSLP:   clk_sel = CSEL_SUB;
            M_STBY, M_WATCH: clk_sel = CSEL_STOP;
            default:         clk_sel = CSEL_FULL;
        endcase
    end

endmodule

// File: rtl/pdm_mode_ctrl.sv
// Module pdm_mode_ctrl: top of the power-down mode controller.
// Assumes the control bits are stable around the sleep strobe and that
// sleep_req is a single-cycle pulse. Outputs are registered-mode decodes.
module pdm_mode_ctrl
    import pdm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sleep_req,
    input  logic                 wake_evt,
    input  logic                 dxfer_en,
    input  logic                 sw_stby,
    input  logic                 med_sel,
    input  logic                 low_sel,
    input  logic                 tmr_sel,
    output logic [NUM_MODES-1:0] mode_oh,
    output logic [CSEL_W-1:0]    clk_sel
);

    ctl_t  ctl;
    mode_e cur_mode;
    mode_e nxt_mode;

    // Bundle the control bits
    always_comb ctl = '{dxfer: dxfer_en, sstby: sw_stby, msel: med_sel,
                        lsel: low_sel, tmode: tmr_sel};

    pdm_next_decode u_dec (
        .cur_mode (cur_mode),
        .sleep_ev (sleep_req),
        .wake_ev  (wake_evt),
        .ctl      (ctl),
        .nxt_mode (nxt_mode)
    );

    pdm_mode_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_mode (nxt_mode),
        .cur_mode (cur_mode)
    );

    pdm_out_encode u_enc (
        .cur_mode (cur_mode),
        .mode_oh  (mode_oh),
        .clk_sel  (clk_sel)
    );

endmodule

// File: rtl/pdm_mode_chk.sv
// Module pdm_mode_chk: property checker bound to pdm_mode_ctrl. It observes
// ports only.
module pdm_mode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       wake_evt,
    input logic       dxfer_en,
    input logic       sw_stby,
    input logic       med_sel,
    input logic       low_sel,
    input logic [6:0] mode_oh,
    input logic [1:0] clk_sel
);

    logic low_pwr;
    logic run_mode;

    // Group the one-hot bits into low-power and running modes
    always_comb low_pwr  = |mode_oh[6:3];
    always_comb run_mode = |mode_oh[2:0];

    a_r13_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_oh) == 1);

    a_r1_reset_mode: assert property (@(posedge clk)
        $rose(rst_n) |-> (mode_oh == 7'b0000001 && clk_sel == 2'b00));

    a_r11_sleep_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (low_pwr && sleep_req && !wake_evt) |=> $stable(mode_oh));

    a_r11_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (run_mode && wake_evt && !sleep_req) |=> $stable(mode_oh));

    a_r4_hs_to_ms: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[0] && sleep_req && dxfer_en && !sw_stby && med_sel && !low_sel)
        |=> mode_oh[1]);

    a_r10_subsleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[4] && wake_evt) |=> mode_oh[2]);

    a_r12_stop_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[5] || mode_oh[6]) |-> clk_sel == 2'b11);

    a_r12_sub_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_oh[2] || mode_oh[4]) |-> clk_sel == 2'b10);

endmodule

bind pdm_mode_ctrl pdm_mode_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .wake_evt  (wake_evt),
    .dxfer_en  (dxfer_en),
    .sw_stby   (sw_stby),
    .med_sel   (med_sel),
    .low_sel   (low_sel),
    .mode_oh   (mode_oh),
    .clk_sel   (clk_sel)
);

// File: tb/pdm_mode_ctrl_tb_top.sv
// Bench for pdm_mode_ctrl: directed corners followed by seeded random stimulus.
// Expected modes come from a bench-side model of the requirements.
module pdm_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake_evt = 1'b0;
    logic       dxfer_en = 1'b0;
    logic       sw_stby = 1'b0;
    logic       med_sel = 1'b0;
    logic       low_sel = 1'b0;
    logic       tmr_sel = 1'b0;
    logic [6:0] mode_oh;
    logic [1:0] clk_sel;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    int exp_m    = 0;
    bit done     = 1'b0;

    // Mode numbers: 0 HS, 1 MS, 2 SUB, 3 SLP, 4 SSLP, 5 STBY, 6 WATCH

    pdm_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_evt(wake_evt),
        .dxfer_en(dxfer_en), .sw_stby(sw_stby), .med_sel(med_sel),
        .low_sel(low_sel), .tmr_sel(tmr_sel), .mode_oh(mode_oh), .clk_sel(clk_sel)
    );

    always #2 clk = ~clk;

    function automatic int model_next(int m, bit s, bit w, bit dx, bit ss, bit ms, bit ls, bit tm);
        int act = ms ? 1 : 0;
        if (m <= 1) begin
            if (!s) return m;
            if (!dx) return !ss ? 3 : (!tm ? 5 : 6);
            if (ss && tm && ls) return 2;
            if (m == 0 && !ss && ms && !ls) return 1;
            if (m == 1 && !ss && !ms && !ls) return 0;
            return m;
        end
        if (m == 2) begin
            if (!s) return m;
            if (!dx) return !ss ? 4 : (tm ? 6 : 2);
            if (ss && tm && !ls) return act;
            return m;
        end
        if (!w) return m;
        if (m == 3 || m == 5) return act;
        if (m == 6) return ls ? 2 : act;
        return 2;
    endfunction

    function automatic string rule_tag(int m, bit s, bit w, bit dx, bit ss, bit tm, bit ls, bit ms);
        if (m <= 1 && s) begin
            if (!dx) return "R2";
            if (ss && tm && ls) return m == 0 ? "R4" : "R5";
            if (!ss && !ls && (m == 0 ? ms : !ms)) return m == 0 ? "R4" : "R5";
            return "R7";
        end
        if (m == 2 && s) begin
            if (!dx) return "R3";
            return (ss && tm && !ls) ? "R6" : "R7";
        end
        if (m >= 3 && w) begin
            if (m == 6) return "R9";
            if (m == 4) return "R10";
            return "R8";
        end
        return "R11";
    endfunction

    function automatic logic [1:0] exp_csel(int m);
        case (m)
            0, 3:    return 2'b00;
            1:       return 2'b01;
            2, 4:    return 2'b10;
            default: return 2'b11;
        endcase
    endfunction

    task automatic check_outputs(string tag);
        n_checks++;
        if (mode_oh !== 7'(1 << exp_m)) begin
            n_fails++;
            $display("FAIL %s mode_oh actual=%b expected=%b", tag, mode_oh, 7'(1 << exp_m));
        end
        n_checks++;
        if (clk_sel !== exp_csel(exp_m)) begin
            n_fails++;
            $display("FAIL R12 clk_sel actual=%b expected=%b", clk_sel, exp_csel(exp_m));
        end
        n_checks++;
        if ($countones(mode_oh) != 1) begin
            n_fails++;
            $display("FAIL R13 bits set actual=%0d expected=1", $countones(mode_oh));
        end
    endtask

    // Drive one cycle of stimulus after a falling edge and check after the next one
    task automatic step(bit s, bit w, bit dx, bit ss, bit ms, bit ls, bit tm);
        string tag;
        sleep_req = s; wake_evt = w; dxfer_en = dx; sw_stby = ss;
        med_sel = ms; low_sel = ls; tmr_sel = tm;
        tag   = rule_tag(exp_m, s, w, dx, ss, tm, ls, ms);
        exp_m = model_next(exp_m, s, w, dx, ss, ms, ls, tm);
        @(posedge clk);
        @(negedge clk);
        check_outputs(tag);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d cycles expected<200000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (3) @(negedge clk);
        exp_m = 0;
        check_outputs("R1");             // R1 during reset
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check_outputs("R1");             // R1 after reset release

        // Directed corners (arguments: s w dx ss ms ls tm)
        step(1,0,1,0,1,0,0);   // R4 HS -> MS
        step(1,0,1,0,0,0,0);   // R5 MS -> HS
        step(1,0,1,1,0,0,1);   // R7 HS stays, no low-sel
        step(1,0,1,1,0,1,1);   // R4 HS -> SUB
        step(1,0,0,1,0,0,0);   // R3 SUB stays
        step(1,0,1,1,1,1,1);   // R7 SUB stays
        step(1,0,1,1,1,0,1);   // R6 SUB -> MS
        step(1,0,1,1,0,1,1);   // R5 MS -> SUB
        step(1,0,1,1,0,0,1);   // R6 SUB -> HS
        step(1,0,0,1,0,0,0);   // R2 HS -> STBY
        step(1,0,0,0,0,0,0);   // R11 sleep in STBY ignored
        step(0,1,0,0,1,0,0);   // R8 STBY -> MS
        step(0,1,0,0,0,0,0);   // R11 wake in MS ignored
        step(1,0,0,1,0,0,1);   // R2 MS -> WATCH
        step(0,1,0,0,0,1,0);   // R9 WATCH -> SUB
        step(1,0,0,0,0,0,0);   // R3 SUB -> SSLP
        step(0,1,0,0,0,0,0);   // R10 SSLP -> SUB
        step(1,0,0,1,0,0,1);   // R3 SUB -> WATCH
        step(0,1,0,0,0,0,0);   // R9 WATCH -> HS
        step(1,0,0,0,0,0,0);   // R2 HS -> SLP
        step(0,1,0,0,0,0,0);   // R8 SLP -> HS

        // Seeded random run
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] c;
            c = 5'($urandom);
            step(($urandom % 3) == 0, ($urandom % 4) == 0, c[4], c[3], c[2], c[1], c[0]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule